// File: doc/BRIEF.md
# Command Ring Fetch Engine

This block sits on the controller side of a codec link and drains a circular ring of 32-bit command words held in system memory. Software places commands into the ring and then moves the write pointer to the index of the newest entry; the engine reads each pending entry through a single-beat memory read port and presents it on a valid/ready command output that feeds the serial link transmitter. The ring has 256 slots and the index arithmetic wraps modulo 256.

Four 16-bit registers form the host view: write pointer, read pointer, control and size. The read pointer always names the last entry that the link accepted. It can only be forced to zero through a two-phase handshake. The run bit in the control register stays visible as set until the engine has truly gone idle, so software can tell when a stop request has taken effect. Faults are recorded in sticky status bits: a memory read error, and a command whose codec address is outside the supported range.

Top module: `cmd_ring_fetch`

## Requirements
- R1: After reset, the write pointer (offset 0), read pointer (offset 1), control (offset 2) and size (offset 3) registers all read 0x0000.
- R2: While run (control bit 0) is set and size reads 2, the engine fetches ring indices read pointer + 1 through the write pointer in order, one at a time, with the index presented on memRdIdx. It sends each word on cmdData. The read pointer increments by one for each command the link accepts and wraps from 255 to 0.
- R3: While cmdValid is high and cmdReady is low, cmdValid stays high and cmdData holds its value.
- R4: No fetch starts unless the size register (bits 1:0) holds the value 2. Run may be set without effect.
- R5: After the host clears run while a command is in flight, control bit 0 keeps reading 1 until that command is accepted. It then reads 0, and no further fetch starts.
- R6: A write to the read pointer register with bit 15 set forces the pointer to 0, and the register then reads 0x8000. While bit 15 is held, no fetch starts. A write with bit 15 clear releases the reset, and the register reads exactly 0. Otherwise the pointer bits of that register ignore host writes.
- R7: Control bit 3 reads 1 exactly when (write pointer + 1) mod 256 equals the read pointer.
- R8: A command whose bits 31:28 are not below NUM_CODECS (default 4) is still sent. Its acceptance sets the sticky control bit 2, and writing 1 to bit 2 clears it.
- R9: A memory read error clears run, sets the sticky control bit 1 (writing 1 clears it), sends no command, and leaves the read pointer unchanged.
- R10: While pwrDown is high, the write pointer and read pointer registers read 0xFFFF, register writes are ignored, and no fetch starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwrDown | input | 1 | Block is powered down |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 write ptr, 1 read ptr, 2 control, 3 size |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data for regAddr |
| memRdEn | output | 1 | Ring read request, one cycle |
| memRdIdx | output | 8 | Ring index to read |
| memRdData | input | 32 | Ring read data |
| memRdValid | input | 1 | Read data valid |
| memRdErr | input | 1 | Read failed |
| cmdValid | output | 1 | Command word available |
| cmdData | output | 32 | Command word |
| cmdReady | input | 1 | Link accepts the command |

## Verification
The bench walks the ring across its wrap point. A design that used the wrong modulus or started at the read pointer rather than one past it would send the wrong words or stall short of the write pointer. A stop request is issued while the link holds off a command. An engine that drops run at once would lose or duplicate that command, and one that keeps fetching would move the read pointer further. The pointer-reset handshake is checked in both phases along with the first index fetched afterwards, which exposes a design that reads back the acknowledge bit wrongly or resumes from a stale index. A memory error, an out-of-range codec address and a power-down window are each injected to show that the sticky bits, the stopping behaviour and the frozen 0xFFFF readback are correct.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_SEND
  } fetchState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic issueRd;
    logic capture;
    logic advance;
    logic memFail;
  } ctrlStb_t;

  localparam logic [1:0] REG_WP   = 2'd0;
  localparam logic [1:0] REG_RP   = 2'd1;
  localparam logic [1:0] REG_CTL  = 2'd2;
  localparam logic [1:0] REG_SIZE = 2'd3;
endpackage

// File: rtl/cmd_ring_ctrl.sv
module cmd_ring_ctrl
  import cmd_ring_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     canFetch,
  input  logic     ctrlWr,
  input  logic     wrRun,
  input  logic     memRdValid,
  input  logic     memRdErr,
  input  logic     cmdReady,
  output ctrlStb_t stb,
  output logic     runBit,
  output logic     memRdEn,
  output logic     cmdValid
);
  fetchState_t state, stateNext;
  logic runReq;

  always_comb begin
    stb       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: if (runReq && canFetch) stateNext = ST_REQ;
      ST_REQ: begin
        stb.issueRd = 1'b1;
        stateNext   = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRdErr) begin
          stb.memFail = 1'b1;
          stateNext   = ST_IDLE;
        end else if (memRdValid) begin
          stb.capture = 1'b1;
          stateNext   = ST_SEND;
        end
      end
      ST_SEND: begin
        if (cmdReady) begin
          stb.advance = 1'b1;
          stateNext   = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      runReq <= 1'b0;
    end else begin
      state <= stateNext;
      if (stb.memFail) runReq <= 1'b0;
      else if (ctrlWr) runReq <= wrRun;
    end
  end

  assign memRdEn  = (state == ST_REQ);
  assign cmdValid = (state == ST_SEND);
  assign runBit   = runReq || (state != ST_IDLE);

  AST_SEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid && !cmdReady |=> cmdValid); // R3
  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    memRdEn |=> !memRdEn); // R2
  AST_MEMFAIL_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && memRdErr) |=> !runBit && !cmdValid); // R9
  AST_STOP_AFTER_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(runBit) |-> !cmdValid && !memRdEn); // R5
endmodule

// File: rtl/cmd_ring_dp.sv
module cmd_ring_dp
  import cmd_ring_pkg::*;
#(
  parameter int PTR_W      = 8,
  parameter int DATA_W     = 32,
  parameter int REG_W      = 16,
  parameter int NUM_CODECS = 4,
  parameter int SIZE_CODE  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwrDown,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  ctrlStb_t          stb,
  input  logic              runBit,
  input  logic              cmdValid,
  input  logic              cmdReady,
  input  logic [DATA_W-1:0] memRdData,
  output logic [PTR_W-1:0]  memRdIdx,
  output logic [DATA_W-1:0] cmdData,
  output logic              canFetch,
  output logic              ctrlWr,
  output logic              wrRun
);
  localparam int CA_W     = 4;
  localparam int RST_BIT  = REG_W - 1;
  localparam logic [CA_W:0] CODEC_LIM = (CA_W+1)'(NUM_CODECS);
  localparam logic [1:0] SIZE_OK = 2'(SIZE_CODE);

  logic [PTR_W-1:0]  wpReg, rpReg;
  logic              rstFlag;
  logic [1:0]        sizeReg;
  logic              memErrFlag, addrErrFlag;
  logic [DATA_W-1:0] cmdBuf;
  logic              wrOk, ringFull, codecBad;
  logic [CA_W-1:0]   codecField;

  assign wrOk   = regWrEn && !pwrDown;
  assign ctrlWr = wrOk && (regAddr == REG_CTL);
  assign wrRun  = regWrData[0];

  assign codecField = cmdBuf[DATA_W-1 -: CA_W];
  assign codecBad   = ({1'b0, codecField} >= CODEC_LIM);
  assign ringFull   = (PTR_W'(wpReg + 1'b1) == rpReg);

  assign canFetch = (rpReg != wpReg) && !rstFlag && (sizeReg == SIZE_OK) && !pwrDown;
  assign memRdIdx = PTR_W'(rpReg + 1'b1);
  assign cmdData  = cmdBuf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wpReg       <= '0;
      rpReg       <= '0;
      rstFlag     <= 1'b0;
      sizeReg     <= '0;
      memErrFlag  <= 1'b0;
      addrErrFlag <= 1'b0;
      cmdBuf      <= '0;
    end else begin
      if (wrOk && regAddr == REG_WP) wpReg <= regWrData[PTR_W-1:0];

      if (wrOk && regAddr == REG_RP) begin
        if (regWrData[RST_BIT]) begin
          rpReg   <= '0;
          rstFlag <= 1'b1;
        end else begin
          rstFlag <= 1'b0;
        end
      end else if (stb.advance && !rstFlag) begin
        rpReg <= PTR_W'(rpReg + 1'b1);
      end

      if (wrOk && regAddr == REG_SIZE) sizeReg <= regWrData[1:0];

      if (stb.memFail) memErrFlag <= 1'b1;
      else if (ctrlWr && regWrData[1]) memErrFlag <= 1'b0;

      if (stb.advance && codecBad) addrErrFlag <= 1'b1;
      else if (ctrlWr && regWrData[2]) addrErrFlag <= 1'b0;

      if (stb.capture) cmdBuf <= memRdData;
    end
  end

  always_comb begin
    unique case (regAddr)
      REG_WP:  regRdData = pwrDown ? '1 : {{(REG_W-PTR_W){1'b0}}, wpReg};
      REG_RP:  regRdData = pwrDown ? '1 : {rstFlag, {(REG_W-PTR_W-1){1'b0}}, rpReg};
      REG_CTL: regRdData = {{(REG_W-4){1'b0}}, ringFull, addrErrFlag, memErrFlag, runBit};
      default: regRdData = {{(REG_W-2){1'b0}}, sizeReg};
    endcase
  end

  AST_RP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rpReg) |-> (rpReg == PTR_W'($past(rpReg) + 1'b1)) || (rpReg == '0)); // R2
  AST_READ_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    stb.issueRd |-> rpReg != wpReg); // R2
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid && !cmdReady |=> $stable(cmdData)); // R3
  AST_PWR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    pwrDown |=> $stable(wpReg)); // R10
endmodule

// File: rtl/cmd_ring_fetch.sv
module cmd_ring_fetch
  import cmd_ring_pkg::*;
#(
  parameter int PTR_W      = 8,
  parameter int DATA_W     = 32,
  parameter int REG_W      = 16,
  parameter int NUM_CODECS = 4,
  parameter int SIZE_CODE  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwrDown,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              memRdEn,
  output logic [PTR_W-1:0]  memRdIdx,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              memRdValid,
  input  logic              memRdErr,
  output logic              cmdValid,
  output logic [DATA_W-1:0] cmdData,
  input  logic              cmdReady
);
  ctrlStb_t stb;
  logic canFetch, ctrlWr, wrRun, runBit;

  cmd_ring_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .canFetch   (canFetch),
    .ctrlWr     (ctrlWr),
    .wrRun      (wrRun),
    .memRdValid (memRdValid),
    .memRdErr   (memRdErr),
    .cmdReady   (cmdReady),
    .stb        (stb),
    .runBit     (runBit),
    .memRdEn    (memRdEn),
    .cmdValid   (cmdValid)
  );

  cmd_ring_dp #(
    .PTR_W      (PTR_W),
    .DATA_W     (DATA_W),
    .REG_W      (REG_W),
    .NUM_CODECS (NUM_CODECS),
    .SIZE_CODE  (SIZE_CODE)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwrDown   (pwrDown),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .stb       (stb),
    .runBit    (runBit),
    .cmdValid  (cmdValid),
    .cmdReady  (cmdReady),
    .memRdData (memRdData),
    .memRdIdx  (memRdIdx),
    .cmdData   (cmdData),
    .canFetch  (canFetch),
    .ctrlWr    (ctrlWr),
    .wrRun     (wrRun)
  );
endmodule

// File: tb/tb_cmd_ring_fetch.sv
module tb_cmd_ring_fetch;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 6;
  localparam logic [7:0] WP_SEQ [NB] = '{8'd5, 8'd40, 8'd200, 8'd255, 8'd3, 8'd10};
  localparam bit STALL_SEQ [NB] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwrDown = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [15:0] regWrData = 16'd0;
  logic [15:0] regRdData;
  logic memRdEn;
  logic [7:0] memRdIdx;
  logic [31:0] memRdData = 32'd0;
  logic memRdValid = 1'b0;
  logic memRdErr = 1'b0;
  logic cmdValid;
  logic [31:0] cmdData;
  logic cmdReady;

  logic errArm = 1'b0;
  logic readyBlock = 1'b0;
  logic stallMode = 1'b0;
  logic [1:0] stallCnt = 2'd0;
  logic [31:0] sentLog [1024];
  int sentCnt = 0;
  int holdErr = 0;
  logic prevHold = 1'b0;
  logic [31:0] prevData = 32'd0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_ring_fetch dut (
    .clk(clk), .rst_n(rst_n), .pwrDown(pwrDown),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .memRdEn(memRdEn), .memRdIdx(memRdIdx), .memRdData(memRdData),
    .memRdValid(memRdValid), .memRdErr(memRdErr),
    .cmdValid(cmdValid), .cmdData(cmdData), .cmdReady(cmdReady)
  );

  function automatic logic [31:0] entryOf(input logic [7:0] i);
    logic [3:0] ca;
    ca = (i == 8'd7) ? 4'hC : {2'b00, i[1:0]};
    return {ca, 4'h0, i ^ 8'h5A, 8'h3C, i};
  endfunction

  // Ring memory model: one-cycle read latency
  always @(posedge clk) begin
    memRdValid <= memRdEn && !errArm;
    memRdErr   <= memRdEn && errArm;
    memRdData  <= entryOf(memRdIdx);
  end

  always @(negedge clk) stallCnt <= stallCnt + 2'd1;
  assign cmdReady = readyBlock ? 1'b0 : (stallMode ? (stallCnt != 2'd0) : 1'b1);

  // Link-side monitor
  always @(posedge clk) begin
    if (rst_n) begin
      if (cmdValid && cmdReady) begin
        sentLog[sentCnt] <= cmdData;
        sentCnt <= sentCnt + 1;
      end
      if (prevHold && (!cmdValid || cmdData !== prevData)) holdErr <= holdErr + 1;
      prevHold <= cmdValid && !cmdReady;
      prevData <= cmdData;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic waitRp(input logic [7:0] target);
    logic [15:0] d;
    for (int n = 0; n < 4000; n++) begin
      regRead(2'd1, d);
      if (d[7:0] == target) break;
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [15:0] d;
    logic [7:0] prevWp;
    int mark;
    int expCnt;
    bit dataOk;
    logic [31:0] badAct;
    logic [31:0] badExp;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    regRead(2'd0, d); check("R1 wp", {16'd0, d}, 32'd0);
    regRead(2'd1, d); check("R1 rp", {16'd0, d}, 32'd0);
    regRead(2'd2, d); check("R1 ctl", {16'd0, d}, 32'd0);
    regRead(2'd3, d); check("R1 size", {16'd0, d}, 32'd0);

    // R4 size gate
    regWrite(2'd0, 16'd2);
    regWrite(2'd2, 16'h0001);
    repeat (20) @(negedge clk);
    check("R4 no send with size 0", sentCnt, 0);
    regRead(2'd2, d); check("R4 run readable", {16'd0, d}, 32'h1);
    regRead(2'd1, d); check("R4 rp held", {16'd0, d}, 32'd0);
    regWrite(2'd3, 16'd2);
    waitRp(8'd2);
    check("R4 sends after size 2", sentCnt, 2);

    // R2/R3 table of batches
    prevWp = 8'd2;
    for (int i = 0; i < NB; i++) begin
      stallMode = STALL_SEQ[i];
      mark = sentCnt;
      regWrite(2'd0, {8'd0, WP_SEQ[i]});
      waitRp(WP_SEQ[i]);
      repeat (2) @(negedge clk);
      expCnt = int'(8'(WP_SEQ[i] - prevWp));
      check("R2 batch count", sentCnt - mark, expCnt);
      dataOk = 1'b1;
      badAct = 32'd0;
      badExp = 32'd0;
      for (int k = 0; k < expCnt; k++) begin
        if (dataOk && sentLog[mark + k] !== entryOf(8'(prevWp + 8'(k) + 8'd1))) begin
          dataOk = 1'b0;
          badAct = sentLog[mark + k];
          badExp = entryOf(8'(prevWp + 8'(k) + 8'd1));
        end
      end
      check("R2 batch order and data", badAct, badExp);
      if (i == 0) begin
        regRead(2'd2, d); check("R8 no flag before bad address", {29'd0, d[2:0]} & 32'h4, 32'h0);
      end
      if (i == 1) begin
        regRead(2'd2, d); check("R8 flag after bad address", {29'd0, d[2:0]} & 32'h4, 32'h4);
        check("R8 bad address still sent", sentLog[mark + 1], entryOf(8'd7));
      end
      prevWp = WP_SEQ[i];
    end
    stallMode = 1'b0;
    check("R3 held while stalled", holdErr, 0);

    // R8 clear
    regWrite(2'd2, 16'h0005);
    regRead(2'd2, d); check("R8 cleared", {16'd0, d}, 32'h1);

    // R7 full flag
    regWrite(2'd2, 16'h0000);
    regWrite(2'd0, 16'd9);
    regRead(2'd2, d); check("R7 full", {16'd0, d}, 32'h8);
    regWrite(2'd0, 16'd10);
    regRead(2'd2, d); check("R7 not full", {16'd0, d}, 32'h0);

    // R5 stop with a command in flight
    readyBlock = 1'b1;
    regWrite(2'd2, 16'h0001);
    regWrite(2'd0, 16'd11);
    for (int n = 0; n < 50; n++) begin
      @(negedge clk);
      if (cmdValid) break;
    end
    regWrite(2'd2, 16'h0000);
    regRead(2'd2, d); check("R5 run held while busy", {16'd0, d}, 32'h1);
    mark = sentCnt;
    readyBlock = 1'b0;
    repeat (5) @(negedge clk);
    regRead(2'd2, d); check("R5 run drops when idle", {16'd0, d}, 32'h0);
    regRead(2'd1, d); check("R5 in-flight sent", {16'd0, d}, 32'd11);
    regWrite(2'd0, 16'd12);
    repeat (20) @(negedge clk);
    regRead(2'd1, d); check("R5 no fetch after stop", {16'd0, d}, 32'd11);
    check("R5 nothing more sent", sentCnt - mark, 1);

    // R6 read pointer reset handshake
    regWrite(2'd1, 16'h8000);
    regRead(2'd1, d); check("R6 ack reads 0x8000", {16'd0, d}, 32'h8000);
    regWrite(2'd0, 16'd3);
    regWrite(2'd2, 16'h0001);
    mark = sentCnt;
    repeat (20) @(negedge clk);
    check("R6 no fetch while held", sentCnt - mark, 0);
    regWrite(2'd1, 16'h0000);
    regRead(2'd1, d); check("R6 released reads 0", {16'd0, d}, 32'h0);
    waitRp(8'd3);
    repeat (2) @(negedge clk);
    check("R6 resumes at index 1", sentLog[mark], entryOf(8'd1));
    regWrite(2'd1, 16'h0055);
    regRead(2'd1, d); check("R6 pointer not writable", {16'd0, d}, 32'd3);

    // R9 memory error
    errArm = 1'b1;
    mark = sentCnt;
    regWrite(2'd0, 16'd4);
    for (int n = 0; n < 50; n++) begin
      @(posedge clk);
      if (memRdErr) break;
    end
    @(negedge clk);
    errArm = 1'b0;
    repeat (5) @(negedge clk);
    regRead(2'd2, d); check("R9 run cleared, error set", {16'd0, d}, 32'h2);
    regRead(2'd1, d); check("R9 rp unchanged", {16'd0, d}, 32'd3);
    check("R9 nothing sent", sentCnt - mark, 0);
    regWrite(2'd2, 16'h0003);
    waitRp(8'd4);
    repeat (2) @(negedge clk);
    regRead(2'd2, d); check("R9 error cleared", {16'd0, d} & 32'h2, 32'h0);
    check("R9 retry sends entry 4", sentLog[mark], entryOf(8'd4));

    // R10 power down
    pwrDown = 1'b1;
    regRead(2'd0, d); check("R10 wp reads FFFF", {16'd0, d}, 32'hFFFF);
    regRead(2'd1, d); check("R10 rp reads FFFF", {16'd0, d}, 32'hFFFF);
    mark = sentCnt;
    regWrite(2'd0, 16'd20);
    repeat (10) @(negedge clk);
    check("R10 no fetch while down", sentCnt - mark, 0);
    pwrDown = 1'b0;
    regRead(2'd0, d); check("R10 write ignored", {16'd0, d}, 32'd4);

    finishRun();
  end
endmodule